// File: doc/BRIEF.md
# Mode Register Write Scheduler

This block is placed in a DRAM memory controller. Other logic asks it to update one of the device's seven mode registers. It turns each accepted request into a single MODE REGISTER SET command on the command pins, and it drives a deselect in every other cycle. The device's registers start undefined and every write must carry the whole register. For this reason the block keeps a shadow of all seven registers. A request carries a bit mask and new data. Bits outside the mask are taken from the shadow.

Two timers run after each issued command. The first controls when the next mode register write may start. The second controls when the rest of the controller may send any command other than a deselect. Some settings (gear-down, parity or command latency, per-device addressing, reference-voltage training, DLL control) are exempt from one or both of the normal spacings. The requester marks such a write with a skip flag, and the exempt timer then uses a separate per-function wait. The block also decodes CAS latency and burst settings from the shadow of register 0 for the rest of the controller.

Top module: `mrs_sched`

## Requirements
- R1: After reset, `cs_n`, `ras_n`, `cas_n`, `we_n` are 1, `req_ready` and `nonmrs_ok` are 1, and `err` and `init_done` are 0.
- R2: A request accepted on a rising edge (`req_valid` and `req_ready` both high) puts a write command on the pins during the next cycle. In that cycle `cs_n`, `ras_n`, `cas_n` and `we_n` are all 0, `bg[1]` is 0, and `{bg[0], ba[1:0]}` holds the register number.
- R3: In the command cycle, `{a17, a_lo}` carries the merged contents. Masked bits come from `req_data`. Unmasked bits keep the last value written to that register, or 0 if the register has never been written.
- R4: If `req_skip_mrd` was 0 on the previous write, two write commands are at least TMRD cycles apart, and exactly TMRD apart when the second request is already waiting.
- R5: If `req_skip_mod` is 0, `nonmrs_ok` goes low in the command cycle and goes high again TMOD-1 cycles later. A command registered on that edge therefore lands TMOD cycles after the write.
- R6: A write with `req_skip_mrd` = 1 makes the next write wait TEXC cycles instead of TMRD.
- R7: A write with `req_skip_mod` = 1 uses TEXC instead of TMOD for `nonmrs_ok`. A longer wait that is still pending from an earlier write is never shortened.
- R8: A write to register 0 whose merged burst-length field (bits 1:0) equals 2'b11 raises `err` for one cycle, in the cycle a command would have appeared. No command is issued, the shadow is unchanged, and neither timer restarts.
- R9: A request with register number 7 is rejected in the same way as in R8.
- R10: `init_done` rises once each of registers 0 to 6 has been written at least once, and it then stays high.
- R11: `cas_lat` decodes the register-0 code {bit12, bits6:4, bit2}. Codes 0-7 give 9-16. Codes 8-11 give 18, 20, 22, 24. Codes 12-15 give 23, 17, 19, 21. Codes 16-31 give 25-40 (code+9). The decode follows the shadow in the command cycle.
- R12: `burst_len` equals register 0 bits 1:0 and `burst_ilv` equals register 0 bit 3, both taken from the shadow.
- R13: In every cycle without a write command, `cs_n`, `ras_n`, `cas_n` and `we_n` are all 1 (deselect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_mr | input | 3 | Target register number |
| req_data | input | 15 | New contents {A17, A13..A0} |
| req_mask | input | 15 | Bits of req_data to apply |
| req_skip_mrd | input | 1 | Setting is exempt from MRS-to-MRS spacing; use TEXC |
| req_skip_mod | input | 1 | Setting is exempt from MRS-to-other spacing; use TEXC |
| err | output | 1 | One-cycle pulse for a rejected request |
| cs_n | output | 1 | Chip select, low on a write command |
| ras_n | output | 1 | Row strobe pin |
| cas_n | output | 1 | Column strobe pin |
| we_n | output | 1 | Write enable pin |
| bg | output | 2 | Bank group pins |
| ba | output | 2 | Bank address pins |
| a17 | output | 1 | Address bit 17 |
| a_lo | output | 14 | Address bits 13..0 |
| nonmrs_ok | output | 1 | A registered non-MRS command may be issued now |
| init_done | output | 1 | All seven registers have been written |
| cas_lat | output | 6 | Decoded CAS latency in clocks |
| burst_len | output | 2 | Register 0 burst-length field |
| burst_ilv | output | 1 | Register 0 interleaved burst order |

## Verification
A request accepted on an edge produces its command, or its `err` pulse, in the next cycle, unless the write timer is still running. In that case it appears in the first cycle the timer allows. The driver works out that cycle from its own copy of the TMRD/TEXC rule and queues it with the expected pins. The monitor samples on falling edges and compares the cycle number, the pins and the register-0 decode when the item is popped. Once the write has been seen, the monitor moves its own `nonmrs_ok` deadline to the command cycle plus TMOD-1 (or TEXC-1) and checks `nonmrs_ok` against it in every cycle.

// File: rtl/mrs_sched.sv
module mrs_sched #(
  parameter int TMRD = 8,
  parameter int TMOD = 24,
  parameter int TEXC = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_mr,
  input  logic [14:0] req_data,
  input  logic [14:0] req_mask,
  input  logic        req_skip_mrd,
  input  logic        req_skip_mod,
  output logic        err,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  bg,
  output logic [1:0]  ba,
  output logic        a17,
  output logic [13:0] a_lo,
  output logic        nonmrs_ok,
  output logic        init_done,
  output logic [5:0]  cas_lat,
  output logic [1:0]  burst_len,
  output logic        burst_ilv
);
  localparam int NMR = 7;
  localparam int CW = $clog2(TMRD + TMOD + TEXC + 1);
  localparam logic [CW-1:0] MRD_L = CW'(TMRD - 1);
  localparam logic [CW-1:0] MOD_L = CW'(TMOD - 1);
  localparam logic [CW-1:0] EXC_L = CW'(TEXC - 1);

  logic [14:0]   shadow [NMR];
  logic [NMR-1:0] written;
  logic [CW-1:0] mrd_cnt, mod_cnt, mod_dec, mod_new;
  logic [14:0]   cur, merged;
  logic [4:0]    cl_code;
  logic          bad, take;

  assign req_ready = (mrd_cnt == '0);
  assign nonmrs_ok = (mod_cnt == '0);
  assign take      = req_valid && req_ready;
  assign cur       = (req_mr == 3'd7) ? '0 : shadow[req_mr];
  assign merged    = (cur & ~req_mask) | (req_data & req_mask);
  assign bad       = (req_mr == 3'd7) || (req_mr == 3'd0 && merged[1:0] == 2'b11);
  assign mod_dec   = (mod_cnt == '0) ? '0 : mod_cnt - 1'b1;
  assign mod_new   = req_skip_mod ? EXC_L : MOD_L;
  assign init_done = &written;

  assign burst_len = shadow[0][1:0];
  assign burst_ilv = shadow[0][3];
  assign cl_code   = {shadow[0][12], shadow[0][6:4], shadow[0][2]};

  always_comb begin
    if (cl_code[4] || !cl_code[3]) cas_lat = 6'(cl_code) + 6'd9;
    else begin
      case (cl_code[2:0])
        3'd0: cas_lat = 6'd18;
        3'd1: cas_lat = 6'd20;
        3'd2: cas_lat = 6'd22;
        3'd3: cas_lat = 6'd24;
        3'd4: cas_lat = 6'd23;
        3'd5: cas_lat = 6'd17;
        3'd6: cas_lat = 6'd19;
        default: cas_lat = 6'd21;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n    <= 1'b1;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      bg      <= '0;
      ba      <= '0;
      a17     <= 1'b0;
      a_lo    <= '0;
      err     <= 1'b0;
      mrd_cnt <= '0;
      mod_cnt <= '0;
      written <= '0;
      for (int i = 0; i < NMR; i++) shadow[i] <= '0;
    end else begin
      cs_n  <= 1'b1;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      err   <= 1'b0;
      if (mrd_cnt != '0) mrd_cnt <= mrd_cnt - 1'b1;
      mod_cnt <= mod_dec;
      if (take) begin
        if (bad) err <= 1'b1;
        else begin
          cs_n    <= 1'b0;
          ras_n   <= 1'b0;
          cas_n   <= 1'b0;
          we_n    <= 1'b0;
          bg      <= {1'b0, req_mr[2]};
          ba      <= req_mr[1:0];
          a17     <= merged[14];
          a_lo    <= merged[13:0];
          shadow[req_mr]  <= merged;
          written[req_mr] <= 1'b1;
          mrd_cnt <= req_skip_mrd ? EXC_L : MRD_L;
          mod_cnt <= (mod_new > mod_dec) ? mod_new : mod_dec;
        end
      end
    end
  end
endmodule

module mrs_sched_chk #(
  parameter int TMRD = 8,
  parameter int TMOD = 24,
  parameter int TEXC = 16
)(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_skip_mrd,
  input logic       err,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] bg,
  input logic       nonmrs_ok,
  input logic       init_done
);
  logic [7:0] since, gap;
  logic       seen, pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '0;
      gap   <= '0;
      seen  <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (req_valid && req_ready) pend <= req_skip_mrd;
      if (!cs_n) begin
        since <= 8'd1;
        seen  <= 1'b1;
        gap   <= pend ? 8'(TEXC) : 8'(TMRD);
      end else if (since != 8'hff) since <= since + 1'b1;
    end
  end

  // R2
  mrs_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (!ras_n && !cas_n && !we_n && !bg[1]));
  // R2
  mrs_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> $past(req_valid && req_ready));
  // R4
  mrs_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && seen) |-> (since >= gap));
  // R8
  err_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cs_n);
  // R5
  mod_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (TMOD > 1 && TEXC > 1 && !cs_n) |-> !nonmrs_ok);
  // R10
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(init_done));
endmodule

bind mrs_sched mrs_sched_chk #(.TMRD(TMRD), .TMOD(TMOD), .TEXC(TEXC)) u_chk (.*);

// File: tb/mrs_sched_bench.sv
module mrs_sched_bench;
  localparam int TMRD = 4, TMOD = 12, TEXC = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_skip_mrd = 1'b0, req_skip_mod = 1'b0;
  logic [2:0] req_mr = '0;
  logic [14:0] req_data = '0, req_mask = '0;
  logic req_ready, err, cs_n, ras_n, cas_n, we_n, a17, nonmrs_ok, init_done, burst_ilv;
  logic [1:0] bg, ba, burst_len;
  logic [13:0] a_lo;
  logic [5:0] cas_lat;

  mrs_sched #(.TMRD(TMRD), .TMOD(TMOD), .TEXC(TEXC)) u_mrs_sched (.*);

  always #10 clk = ~clk;

  typedef struct {int cyc; bit is_err; bit [2:0] mr; bit [14:0] d; bit smod;} item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0, mrd_from = 0, mod_from = 0;
  bit [14:0] bsh [7];
  bit [6:0] bw = '0;
  bit started = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_cl(bit [14:0] d);
    int c;
    c = {d[12], d[6:4], d[2]};
    if (c < 8 || c > 15) return c + 9;
    if (c < 12) return 18 + 2 * (c - 8);
    case (c)
      12: return 23;
      13: return 17;
      14: return 19;
      default: return 21;
    endcase
  endfunction

  task automatic mrs(input bit [2:0] mr, input bit [14:0] d, input bit [14:0] m,
                     input bit smrd, input bit smod);
    item_t it;
    bit [14:0] cur;
    @(negedge clk);
    req_valid = 1; req_mr = mr; req_data = d; req_mask = m;
    req_skip_mrd = smrd; req_skip_mod = smod;
    cur = (mr == 7) ? 15'd0 : bsh[mr];
    it.d = (cur & ~m) | (d & m);
    it.mr = mr;
    it.smod = smod;
    it.is_err = (mr == 7) || (mr == 0 && it.d[1:0] == 2'b11);
    it.cyc = (cyc + 1 > mrd_from) ? cyc + 1 : mrd_from;
    if (!it.is_err) begin
      bsh[mr] = it.d;
      mrd_from = it.cyc + (smrd ? TEXC : TMRD);
    end
    q.push_back(it);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && started) begin
      if (!cs_n || err) begin
        if (q.size() == 0) chk(0, "R13 unexpected command", 0, 1);
        else begin
          item_t it;
          it = q.pop_front();
          chk(cyc == it.cyc, it.is_err ? "R8/R9 reject cycle" : "R4/R6 issue cycle", cyc, it.cyc);
          if (it.is_err) begin
            chk(err && cs_n, it.mr == 7 ? "R9 rejected" : "R8 rejected", {err, cs_n}, 3);
          end else begin
            chk(!err && !ras_n && !cas_n && !we_n, "R2 command pins", {err, ras_n, cas_n, we_n}, 0);
            chk({bg, ba} == {1'b0, it.mr}, "R2 register select", {bg, ba}, it.mr);
            chk({a17, a_lo} == it.d, "R3 contents", {a17, a_lo}, it.d);
            bw[it.mr] = 1'b1;
            chk(init_done == (&bw), "R10 init_done", init_done, &bw);
            if (it.mr == 0) begin
              chk(cas_lat == exp_cl(it.d), "R11 cas latency", cas_lat, exp_cl(it.d));
              chk({burst_ilv, burst_len} == {it.d[3], it.d[1:0]}, "R12 burst fields",
                  {burst_ilv, burst_len}, {it.d[3], it.d[1:0]});
            end
            if (cyc + (it.smod ? TEXC : TMOD) - 1 > mod_from)
              mod_from = cyc + (it.smod ? TEXC : TMOD) - 1;
          end
        end
      end else begin
        chk(ras_n && cas_n && we_n, "R13 deselect", {ras_n, cas_n, we_n}, 7);
      end
      chk(nonmrs_ok == (cyc >= mod_from), "R5/R7 nonmrs_ok", nonmrs_ok, cyc >= mod_from);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit [4:0] codes [8] = '{5'd3, 5'd8, 5'd11, 5'd12, 5'd13, 5'd15, 5'd16, 5'd23};
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n && ras_n && cas_n && we_n, "R1 pins idle", {cs_n, ras_n, cas_n, we_n}, 15);
    chk(req_ready && nonmrs_ok, "R1 ready", {req_ready, nonmrs_ok}, 3);
    chk(!err && !init_done, "R1 flags", {err, init_done}, 0);
    started = 1;
    // R4 back-to-back full writes; R10 after the last
    mrs(0, 15'h0059, 15'h7fff, 0, 0);
    mrs(1, 15'h4321, 15'h7fff, 0, 0);
    mrs(2, 15'h1aa5, 15'h7fff, 0, 0);
    mrs(3, 15'h0f0f, 15'h7fff, 0, 0);
    mrs(4, 15'h7001, 15'h7fff, 0, 0);
    mrs(5, 15'h2468, 15'h7fff, 0, 0);
    mrs(6, 15'h5555, 15'h7fff, 0, 0);
    // R3 partial write keeps unmasked bits
    mrs(3, 15'h7fff, 15'h00f0, 0, 0);
    mrs(1, 15'h0000, 15'h4003, 0, 0);
    // R8 reserved burst length; R9 register 7
    mrs(0, 15'h0003, 15'h0003, 0, 0);
    mrs(7, 15'h1234, 15'h7fff, 0, 0);
    mrs(0, 15'h0002, 15'h0003, 0, 0);
    // R6 exempt from MRS spacing
    mrs(4, 15'h0abc, 15'h0fff, 1, 0);
    mrs(5, 15'h0123, 15'h0fff, 0, 0);
    repeat (20) @(negedge clk);
    // R7 exempt from non-MRS spacing, then a normal one
    mrs(2, 15'h0002, 15'h000f, 0, 1);
    repeat (20) @(negedge clk);
    mrs(2, 15'h0004, 15'h000f, 0, 0);
    mrs(6, 15'h0011, 15'h00ff, 0, 1);
    repeat (20) @(negedge clk);
    // R11, R12 decode sweep
    foreach (codes[i]) begin
      bit [14:0] d;
      d = (15'(codes[i][4]) << 12) | (15'(codes[i][3:1]) << 4) | (15'(codes[i][0]) << 2);
      d = d | 15'(i[1:0] == 2'b11 ? 2'b10 : i[1:0]) | (15'(i[0]) << 3);
      mrs(0, d, 15'h107f, 0, 0);
    end
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R2 all commands seen", q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule